// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It runs a compact register-register and load/store instruction subset. The subset covers word loads and stores, add, subtract, AND, OR, signed set-on-less-than, a branch taken on equal operands, and an absolute jump. The instruction store and the data store are two separate word arrays inside the core, so a fetch and a data access can both happen in the same cycle. A 32-entry register file, a sign extender, an adder for the branch target and the next-PC selection complete the datapath.

The two arrays are filled through a load port that only acts while reset is held. The host then releases reset, and execution starts at address zero. The core reports its progress on two debug taps. One shows the PC of the instruction being executed. The other shows the register write that instruction commits at the next rising edge. The main decoder looks only at the 6-bit opcode. The arithmetic operation is taken from a 2-bit class code and, for register-register instructions, from the function field.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC and all 32 registers are cleared to zero. After reset is released, execution starts at PC 0.
- R2: The PC is always word aligned. Any instruction that is neither a taken branch nor a jump moves the PC to PC+4.
- R3: An instruction with opcode 0 takes rs from bits 25:21, rt from 20:16 and rd from 15:11. It writes rs op rt into rd. The function field in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed less-than (result 1 or 0).
- R4: Opcode 35 loads the data word at rs plus the sign-extended bits 15:0 into rt. The data word index is address bits [DAW+1:2], so addresses wrap modulo the array size.
- R5: Opcode 43 stores rt to the data word at rs plus the sign-extended offset, at the rising edge. It writes no register.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by two. Otherwise the next PC is PC+4. It writes no register.
- R7: Opcode 2 sets the next PC to bits 31:28 of PC+4, then instruction bits 25:0, then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it changes nothing, and `dbg_wr_en` stays low for it.
- R9: Any opcode other than 0, 2, 4, 35 and 43 only advances the PC. So does opcode 0 with a function code not listed in R3. Neither writes a register or data memory.
- R10: `dbg_wr_en`, `dbg_wr_idx` and `dbg_wr_data` show the register write that the current instruction commits at the next rising edge. `dbg_pc` shows the current PC.
- R11: While `rst` is high, `ld_en` writes `ld_data` at the rising edge into word `ld_addr`. The word goes to the data array when `ld_dmem` is 1 and to the instruction array otherwise. While `rst` is low, `ld_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Array load strobe, honoured only in reset |
| ld_dmem | input | 1 | Load target: 1 = data array, 0 = instruction array |
| ld_addr | input | LDAW | Word index for the load |
| ld_data | input | 32 | Word to load |
| dbg_pc | output | 32 | PC of the instruction now executing |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
The assertions check, on every cycle, the rules that depend on only one instruction at a time. These are PC alignment and the PC+4 step, the taken-branch and jump targets, the no-op behaviour of unknown encodings, the absence of register writes from stores, the constant zero in register 0, the landing of each committed register write, and the lock on the load port outside reset. Other behaviour only shows up in the bench's program, which is checked against an instruction-level model. That program covers the values the operations compute, including signed comparison against a negative operand. It also covers store-then-load round trips, address wrap from a negative offset, the not-taken branch, and a backward branch that loops in place.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XW = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_fn_e;

    typedef enum logic [1:0] {
        CLS_MEM  = 2'b00,
        CLS_CMP  = 2'b01,
        CLS_FUNC = 2'b10,
        CLS_IDLE = 2'b11
    } alu_cls_e;

    typedef struct packed {
        logic     reg_we;
        logic     dst_is_rd;
        logic     b_is_imm;
        logic     wb_from_mem;
        logic     mem_we;
        logic     branch;
        logic     jump;
        alu_cls_e cls;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_fn_e    alu_fn,
    output logic       known
);

    logic fn_ok;

    always_comb begin
        ctl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_is_imm: 1'b0, wb_from_mem: 1'b0,
                mem_we: 1'b0, branch: 1'b0, jump: 1'b0, cls: CLS_IDLE};
        unique case (opcode)
            OPC_REG: begin
                ctl.reg_we    = 1'b1;
                ctl.dst_is_rd = 1'b1;
                ctl.cls       = CLS_FUNC;
            end
            OPC_LOAD: begin
                ctl.reg_we      = 1'b1;
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.cls         = CLS_MEM;
            end
            OPC_STORE: begin
                ctl.b_is_imm = 1'b1;
                ctl.mem_we   = 1'b1;
                ctl.cls      = CLS_MEM;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                ctl.cls    = CLS_CMP;
            end
            OPC_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ;
        endcase
    end

    // second-level decode: class code plus function field
    always_comb begin
        alu_fn = ALU_ADD;
        fn_ok  = 1'b1;
        unique case (ctl.cls)
            CLS_MEM:  alu_fn = ALU_ADD;
            CLS_CMP:  alu_fn = ALU_SUB;
            CLS_FUNC: begin
                unique case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: fn_ok  = 1'b0;
                endcase
            end
            default:  alu_fn = ALU_ADD;
        endcase
    end

    assign known = (opcode == OPC_REG) ? fn_ok
                 : (opcode == OPC_LOAD) || (opcode == OPC_STORE)
                || (opcode == OPC_BEQ)  || (opcode == OPC_JUMP);

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    logic [W-1:0] diff;

    always_comb begin
        diff = a - b;
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    output logic [W-1:0]            rd1,
    output logic [W-1:0]            rd2,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic [W-1:0]            wd
);

    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == AW'(0)) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == AW'(0)) ? '0 : regs_q[ra2];

    AST_ZERO_REG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0)) |=> (regs_q[0] == '0)); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd))); // R10

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int IAW  = $clog2(IMEM_WORDS),
    parameter int DAW  = $clog2(DMEM_WORDS),
    parameter int LDAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_dmem,
    input  logic [LDAW-1:0]  ld_addr,
    input  logic [XW-1:0]    ld_data,
    output logic [XW-1:0]    dbg_pc,
    output logic             dbg_wr_en,
    output logic [RIDX_W-1:0] dbg_wr_idx,
    output logic [XW-1:0]    dbg_wr_data
);

    typedef struct packed {
        logic [XW-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [XW-1:0] imem_q [IMEM_WORDS];
    logic [XW-1:0] imem_d [IMEM_WORDS];
    logic [XW-1:0] dmem_q [DMEM_WORDS];
    logic [XW-1:0] dmem_d [DMEM_WORDS];

    logic [XW-1:0]     instr;
    logic [5:0]        opc;
    logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
    logic [XW-1:0]     sext_imm;
    ctrl_t             ctl;
    alu_fn_e           alu_fn;
    logic              op_known;
    logic [XW-1:0]     rs_val, rt_val;
    logic [XW-1:0]     alu_b, alu_y;
    logic              alu_zero;
    logic [XW-1:0]     load_val, wb_val;
    logic [RIDX_W-1:0] wb_idx;
    logic [XW-1:0]     pc_plus4, br_target, jmp_target;
    logic              take_br;
    logic [DAW-1:0]    d_idx;

    // fetch and field split
    assign instr    = imem_q[st_q.pc[IAW+1:2]];
    assign opc      = instr[31:26];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign sext_imm = {{16{instr[15]}}, instr[15:0]};

    sc_ctrl ctrl_i (
        .opcode (opc),
        .funct  (instr[5:0]),
        .ctl    (ctl),
        .alu_fn (alu_fn),
        .known  (op_known)
    );

    sc_regfile #(.W(XW), .NREG(32)) rf_i (
        .clk (clk),
        .rst (rst),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (ctl.reg_we && op_known),
        .wa  (wb_idx),
        .wd  (wb_val)
    );

    assign alu_b = ctl.b_is_imm ? sext_imm : rt_val;

    sc_alu #(.W(XW)) alu_i (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data access and write-back selection
    assign d_idx    = alu_y[DAW+1:2];
    assign load_val = dmem_q[d_idx];
    assign wb_val   = ctl.wb_from_mem ? load_val : alu_y;
    assign wb_idx   = ctl.dst_is_rd ? f_rd : f_rt;

    // next-PC candidates
    assign pc_plus4   = st_q.pc + 32'd4;
    assign br_target  = pc_plus4 + {sext_imm[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br    = ctl.branch && alu_zero;

    always_comb begin
        st_d = st_q;
        if (take_br) begin
            st_d.pc = br_target;
        end else if (ctl.jump) begin
            st_d.pc = jmp_target;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_comb begin
        imem_d = imem_q;
        dmem_d = dmem_q;
        if (rst) begin
            if (ld_en && ld_dmem) begin
                dmem_d[ld_addr[DAW-1:0]] = ld_data;
            end
            if (ld_en && !ld_dmem) begin
                imem_d[ld_addr[IAW-1:0]] = ld_data;
            end
        end else if (ctl.mem_we) begin
            dmem_d[d_idx] = rt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc <= '0;
        end else begin
            st_q <= st_d;
        end
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign dbg_pc      = st_q.pc;
    assign dbg_wr_en   = ctl.reg_we && op_known && (wb_idx != '0);
    assign dbg_wr_idx  = wb_idx;
    assign dbg_wr_data = wb_val;

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        st_q.pc[1:0] == 2'b00); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (!take_br && !ctl.jump) |=> (st_q.pc == $past(st_q.pc) + 32'd4)); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && (rs_val == rt_val))
        |=> (st_q.pc == $past(st_q.pc) + 32'd4 + {$past(sext_imm[29:0]), 2'b00})); // R6

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JUMP)
        |=> (st_q.pc[27:0] == {$past(instr[25:0]), 2'b00})); // R7

    AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!dbg_wr_en && !ctl.mem_we && !take_br && !ctl.jump)); // R9

    AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_STORE) |-> !dbg_wr_en); // R5

    AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !ld_dmem)
        |=> (imem_q[$past(ld_addr[IAW-1:0])] == $past(imem_q[ld_addr[IAW-1:0]]))); // R11

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_reg  [32];
    logic [31:0] m_dmem [64];
    logic [31:0] m_imem [64];
    logic [31:0] m_pc;
    string       pc_tag;

    always #10 clk = ~clk;

    sc_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_en       (ld_en),
        .ld_dmem     (ld_dmem),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .dbg_pc      (dbg_pc),
        .dbg_wr_en   (dbg_wr_en),
        .dbg_wr_idx  (dbg_wr_idx),
        .dbg_wr_data (dbg_wr_data)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_word(bit to_d, int idx, logic [31:0] val);
        ld_en   = 1'b1;
        ld_dmem = to_d;
        ld_addr = 6'(idx);
        ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        if (to_d) m_dmem[idx] = val;
        else      m_imem[idx] = val;
    endtask

    // compare the taps for the model's current instruction, then step the model
    task automatic compare_and_step();
        logic [31:0] ins, a, b, res, nxt, sx;
        logic [5:0]  op, fn;
        bit          we, valid;
        int          dst;
        string       req;
        ins = m_imem[m_pc[7:2]];
        op  = ins[31:26];
        fn  = ins[5:0];
        a   = m_reg[ins[25:21]];
        b   = m_reg[ins[20:16]];
        sx  = {{16{ins[15]}}, ins[15:0]};
        nxt = m_pc + 4;
        we  = 0; dst = 0; res = 0; valid = 1;
        req = "R9";
        check(pc_tag, "dbg_pc", dbg_pc, m_pc);
        case (op)
            6'd0: begin
                req = "R3";
                dst = int'(ins[15:11]);
                we  = 1;
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin we = 0; valid = 0; req = "R9"; end
                endcase
            end
            6'd35: begin
                req = "R4";
                dst = int'(ins[20:16]);
                we  = 1;
                res = m_dmem[(a + sx) >> 2 & 32'h3F];
            end
            6'd43: begin
                req = "R5";
                m_dmem[(a + sx) >> 2 & 32'h3F] = b;
            end
            6'd4: begin
                req = "R6";
                if (a == b) nxt = m_pc + 4 + (sx << 2);
            end
            6'd2: begin
                req = "R7";
                nxt = {m_pc[31:28] + 4'(0), ins[25:0], 2'b00};
                nxt[31:28] = (m_pc + 4) >> 28;
            end
            default: valid = 0;
        endcase
        if (we && dst == 0) begin
            we  = 0;
            req = "R8";
        end
        // R10: the write taps announce the commit of this cycle
        check({req, " R10"}, "dbg_wr_en", {31'd0, dbg_wr_en}, {31'd0, we});
        if (we) begin
            check({req, " R10"}, "dbg_wr_idx", {27'd0, dbg_wr_idx}, 32'(dst));
            check({req, " R10"}, "dbg_wr_data", dbg_wr_data, res);
            m_reg[dst] = res;
        end
        m_pc   = nxt;
        pc_tag = (op == 6'd4) ? "R6" : (op == 6'd2) ? "R7" : "R2";
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) begin
            m_imem[i] = '0;
            m_dmem[i] = '0;
        end
        m_pc   = '0;
        pc_tag = "R1";
        @(negedge clk);
        for (int i = 0; i < 64; i++) load_word(1, i, 32'(i) * 32'h0101);
        for (int i = 0; i < 64; i++) load_word(0, i, {6'h3F, 26'd0});
        load_word(1, 0, 32'd5);
        load_word(1, 1, 32'hFFFF_FFFD);
        load_word(1, 63, 32'h0000_1234);
        load_word(0, 0,  enc_i(6'd35, 0, 1, 0));
        load_word(0, 1,  enc_i(6'd35, 0, 2, 4));
        load_word(0, 2,  enc_r(1, 2, 3, 6'h20));
        load_word(0, 3,  enc_r(1, 2, 4, 6'h22));
        load_word(0, 4,  enc_r(1, 2, 5, 6'h24));
        load_word(0, 5,  enc_r(1, 2, 6, 6'h25));
        load_word(0, 6,  enc_r(2, 1, 7, 6'h2A));
        load_word(0, 7,  enc_r(1, 2, 8, 6'h2A));
        load_word(0, 8,  enc_i(6'd43, 0, 3, 8));
        load_word(0, 9,  enc_i(6'd35, 0, 9, 8));
        load_word(0, 10, enc_r(1, 1, 0, 6'h20));
        load_word(0, 11, enc_r(0, 1, 10, 6'h20));
        load_word(0, 12, enc_i(6'd4, 1, 2, 5));
        load_word(0, 13, enc_i(6'd4, 9, 3, 2));
        load_word(0, 14, enc_r(1, 1, 11, 6'h20));
        load_word(0, 15, enc_r(1, 1, 11, 6'h20));
        load_word(0, 16, {6'h3F, 5'd1, 5'd2, 16'h0000});
        load_word(0, 17, enc_r(1, 2, 12, 6'h00));
        load_word(0, 18, enc_i(6'd35, 14, 13, -4));
        load_word(0, 19, enc_i(6'd43, 0, 2, 32));
        load_word(0, 20, enc_i(6'd35, 0, 15, 32));
        load_word(0, 21, {6'd2, 26'd24});
        load_word(0, 22, enc_r(1, 1, 16, 6'h20));
        load_word(0, 23, enc_r(1, 1, 16, 6'h20));
        load_word(0, 24, enc_i(6'd4, 0, 0, -1));
        // R1: reset holds the PC at zero
        check("R1", "dbg_pc in reset", dbg_pc, 32'd0);
        rst = 1'b0;
        for (int cyc = 0; cyc < 40; cyc++) begin
            if (cyc == 30) begin
                // R11: load strobe outside reset must not alter the looping word
                ld_en   = 1'b1;
                ld_dmem = 1'b0;
                ld_addr = 6'd24;
                ld_data = {6'd2, 26'd4};
                pc_tag  = "R11";
            end else begin
                ld_en = 1'b0;
            end
            compare_and_step();
            @(negedge clk);
        end
        check("R11", "dbg_pc after ignored load", dbg_pc, 32'd96);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule